// File: doc/BRIEF.md
# Triggered Ping-Pong Pulse Sequencer

This block produces one digital pulse train for each trigger. The train opens with a programmed start delay, during which the output is held low. It then alternates high and low segments. Each segment has its own length, counted in ticks of an external 1 µs enable. Every output edge is caused by a hardware counter reaching its end, so no software sits in the timing path and the edges do not jitter.

Two loadable duration counters share the work. One times high segments and the other times low segments. When the running counter expires, the other counter takes over on that same tick and the output toggles. A reload request is then raised for the counter that just finished. The host only has to write the next length before the segment now running ends. A third counter times the start delay.

A duration of zero ends the train. If the host misses a reload, the train aborts and a sticky flag records the underrun. Each trigger may start a completely different train.

Top module: `pseq_top`

## Requirements
- R1: After reset, pulse_o, busy_o, done_o, underrun_o and reload_req_o are all 0.
- R2: Host writes use wr_addr_i 0 for the start delay, 1 for the high counter and 2 for the low counter. A trigger in idle raises busy_o on the next clock and loads the delay on the next tick_i. The first high segment begins D ticks after that tick, so D = 0 starts it on that same tick.
- R3: A counter loaded with N ≥ 1 holds its level for exactly N ticks. Segments alternate high and low, starting with the high counter.
- R4: When the running counter expires, the other counter starts on that tick, pulse_o toggles, and reload_req_o rises with reload_sel_o naming the expired counter (0 = high, 1 = low). pulse_o changes only on tick cycles.
- R5: Writing the pending counter clears reload_req_o. A write that lands in the very cycle of the running counter's expiry counts as in time, and its value is used.
- R6: If the counter about to start has not been written since its last use, the train aborts. pulse_o is forced low, busy_o drops and underrun_o sets. underrun_o stays set until the next accepted trigger.
- R7: If the counter about to start holds zero, pulse_o goes low, done_o pulses for exactly one cycle and the block returns to idle.
- R8: A trigger while busy_o is 1 is ignored: the running train is not altered and no new train follows it.
- R9: A host write to the counter that is currently running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | 1 µs time-base enable, one cycle wide |
| trig_i | input | 1 | Start request |
| wr_en_i | input | 1 | Host write strobe |
| wr_addr_i | input | 2 | Write target: 0 delay, 1 high counter, 2 low counter |
| wr_data_i | input | DUR_W | Duration in ticks |
| pulse_o | output | 1 | Generated pulse train |
| busy_o | output | 1 | Train in progress |
| done_o | output | 1 | One-cycle end-of-train strobe |
| underrun_o | output | 1 | Sticky missed-reload flag |
| reload_req_o | output | 1 | A counter awaits its next value |
| reload_sel_o | output | 1 | Counter awaiting reload: 0 high, 1 low |

## Verification
Two functions can fall in the same cycle: the host's reload write of the idle counter, and the expiry of the running counter that hands control to it. The bench provokes this collision by counting ticks after the reload request and asserting the write exactly on the expiry tick. The collision is judged correct when three things hold: the next segment has the newly written length, no underrun is flagged, and the request moves to the other counter. Other runs cover a missed reload, a zero-length first segment, triggers issued mid-train, and writes aimed at the running counter.

// File: rtl/pseq_pkg.sv
package pseq_pkg;
  localparam int unsigned ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_DELAY = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_HIGH  = 2'd1;
  localparam int unsigned N_SLOT = 2;
  localparam logic SLOT_HIGH = 1'b0;
  localparam logic SLOT_LOW  = 1'b1;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_DELAY = 2'd2,
    ST_RUN   = 2'd3
  } seq_state_e;
endpackage

// File: rtl/pseq_down_cnt.sv
module pseq_down_cnt #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         dec_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (load_i)                cnt_q <= load_val_i;
    else if (dec_i && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/pseq_seg_slot.sv
module pseq_seg_slot #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         run_tick_i,
  input  logic         expire_i,
  output logic         eff_loaded_o,
  output logic         eff_zero_o,
  output logic         last_o
);
  logic [W-1:0] cnt;
  logic         loaded_q;

  pseq_down_cnt #(.W(W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (wr_i),
    .load_val_i(wr_data_i),
    .dec_i     (run_tick_i),
    .cnt_o     (cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        loaded_q <= 1'b0;
    else if (wr_i)      loaded_q <= 1'b1;
    else if (expire_i)  loaded_q <= 1'b0;
  end

  // bypass so a write on the hand-off tick is honoured
  assign eff_loaded_o = loaded_q | wr_i;
  assign eff_zero_o   = wr_i ? (wr_data_i == '0) : (cnt == '0);
  assign last_o       = (cnt == W'(1));
endmodule

// File: rtl/pseq_ctrl.sv
module pseq_ctrl
  import pseq_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              trig_i,
  input  logic [W-1:0]      dly_val_i,
  input  logic              dly_last_i,
  input  logic [N_SLOT-1:0] eff_loaded_i,
  input  logic [N_SLOT-1:0] eff_zero_i,
  input  logic [N_SLOT-1:0] last_i,
  input  logic [N_SLOT-1:0] wr_hit_i,
  output logic              dly_load_o,
  output logic              dly_dec_o,
  output logic [N_SLOT-1:0] run_tick_o,
  output logic [N_SLOT-1:0] expire_o,
  output logic              running_o,
  output logic              active_o,
  output logic              pulse_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              underrun_o,
  output logic              req_o,
  output logic              req_sel_o
);
  seq_state_e state_q, state_d;
  logic active_q, active_d;
  logic pulse_q, pulse_d;
  logic done_q, done_d;
  logic under_q, under_d;
  logic req_q, req_d;
  logic sel_q, sel_d;
  logic go_start, go_slot, hand_off;

  always_comb begin
    state_d  = state_q;
    active_d = active_q;
    pulse_d  = pulse_q;
    done_d   = 1'b0;
    under_d  = under_q;
    req_d    = req_q;
    sel_d    = sel_q;
    dly_load_o = 1'b0;
    expire_o   = '0;
    go_start = 1'b0;
    go_slot  = SLOT_HIGH;
    hand_off = 1'b0;

    if (req_q && wr_hit_i[sel_q]) req_d = 1'b0;

    unique case (state_q)
      ST_IDLE: begin
        if (trig_i) begin
          state_d = ST_ARMED;
          under_d = 1'b0;
        end
      end
      ST_ARMED: begin
        if (tick_i) begin
          dly_load_o = 1'b1;
          if (dly_val_i == '0) go_start = 1'b1;
          else                 state_d  = ST_DELAY;
        end
      end
      ST_DELAY: begin
        if (tick_i && dly_last_i) go_start = 1'b1;
      end
      ST_RUN: begin
        if (tick_i && last_i[active_q]) begin
          expire_o[active_q] = 1'b1;
          go_start = 1'b1;
          go_slot  = ~active_q;
          hand_off = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase

    if (go_start) begin
      if (!eff_loaded_i[go_slot]) begin
        under_d = 1'b1;
        pulse_d = 1'b0;
        state_d = ST_IDLE;
        req_d   = 1'b0;
      end else if (eff_zero_i[go_slot]) begin
        done_d  = 1'b1;
        pulse_d = 1'b0;
        state_d = ST_IDLE;
        req_d   = 1'b0;
      end else begin
        state_d  = ST_RUN;
        active_d = go_slot;
        pulse_d  = (go_slot == SLOT_HIGH);
        if (hand_off) begin
          req_d = 1'b1;
          sel_d = active_q;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      active_q <= SLOT_HIGH;
      pulse_q  <= 1'b0;
      done_q   <= 1'b0;
      under_q  <= 1'b0;
      req_q    <= 1'b0;
      sel_q    <= SLOT_HIGH;
    end else begin
      state_q  <= state_d;
      active_q <= active_d;
      pulse_q  <= pulse_d;
      done_q   <= done_d;
      under_q  <= under_d;
      req_q    <= req_d;
      sel_q    <= sel_d;
    end
  end

  assign dly_dec_o = (state_q == ST_DELAY) && tick_i;

  for (genvar g = 0; g < N_SLOT; g++) begin : g_run
    assign run_tick_o[g] = (state_q == ST_RUN) && (active_q == g[0]) && tick_i;
  end

  assign running_o  = (state_q == ST_RUN);
  assign active_o   = active_q;
  assign pulse_o    = pulse_q;
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = done_q;
  assign underrun_o = under_q;
  assign req_o      = req_q;
  assign req_sel_o  = sel_q;
endmodule

// File: rtl/pseq_top.sv
module pseq_top
  import pseq_pkg::*;
#(
  parameter int unsigned DUR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              trig_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DUR_W-1:0]  wr_data_i,
  output logic              pulse_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              underrun_o,
  output logic              reload_req_o,
  output logic              reload_sel_o
);
  logic [DUR_W-1:0]  dly_reg_q;
  logic [DUR_W-1:0]  dly_cnt;
  logic              dly_load, dly_dec;
  logic [N_SLOT-1:0] eff_loaded, eff_zero, last, wr_hit, run_tick, expire;
  logic              running, active;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                     dly_reg_q <= '0;
    else if (wr_en_i && wr_addr_i == ADDR_DELAY)     dly_reg_q <= wr_data_i;
  end

  pseq_down_cnt #(.W(DUR_W)) u_dly (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (dly_load),
    .load_val_i(dly_reg_q),
    .dec_i     (dly_dec),
    .cnt_o     (dly_cnt)
  );

  for (genvar g = 0; g < N_SLOT; g++) begin : g_slot
    // writes to the counter in use are dropped
    assign wr_hit[g] = wr_en_i && (wr_addr_i == ADDR_HIGH + ADDR_W'(g))
                       && !(running && active == g[0]);

    pseq_seg_slot #(.W(DUR_W)) u_slot (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .wr_i        (wr_hit[g]),
      .wr_data_i   (wr_data_i),
      .run_tick_i  (run_tick[g]),
      .expire_i    (expire[g]),
      .eff_loaded_o(eff_loaded[g]),
      .eff_zero_o  (eff_zero[g]),
      .last_o      (last[g])
    );
  end

  pseq_ctrl #(.W(DUR_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick_i),
    .trig_i      (trig_i),
    .dly_val_i   (dly_reg_q),
    .dly_last_i  (dly_cnt == DUR_W'(1)),
    .eff_loaded_i(eff_loaded),
    .eff_zero_i  (eff_zero),
    .last_i      (last),
    .wr_hit_i    (wr_hit),
    .dly_load_o  (dly_load),
    .dly_dec_o   (dly_dec),
    .run_tick_o  (run_tick),
    .expire_o    (expire),
    .running_o   (running),
    .active_o    (active),
    .pulse_o     (pulse_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .underrun_o  (underrun_o),
    .req_o       (reload_req_o),
    .req_sel_o   (reload_sel_o)
  );
endmodule

// File: rtl/pseq_checker.sv
module pseq_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic tick_i,
  input logic trig_i,
  input logic pulse_o,
  input logic busy_o,
  input logic done_o,
  input logic underrun_o,
  input logic reload_req_o
);
  assert_pulse_in_train_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |-> busy_o);

  assert_edge_on_tick_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(pulse_o) |-> $past(tick_i));

  assert_req_in_train_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_req_o |-> busy_o);

  assert_underrun_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (underrun_o && !(trig_i && !busy_o)) |=> underrun_o);

  assert_done_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_end_reason_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (done_o || underrun_o));
endmodule

bind pseq_top pseq_checker u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tick_i      (tick_i),
  .trig_i      (trig_i),
  .pulse_o     (pulse_o),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .underrun_o  (underrun_o),
  .reload_req_o(reload_req_o)
);

// File: tb/pseq_top_bench.sv
module pseq_top_bench;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic tick_i = 1'b0;
  logic trig_i = 1'b0;
  logic wr_en_i = 1'b0;
  logic [1:0] wr_addr_i = '0;
  logic [DW-1:0] wr_data_i = '0;
  logic pulse_o, busy_o, done_o, underrun_o, reload_req_o, reload_sel_o;

  pseq_top #(.DUR_W(DW)) u_pseq_top (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .trig_i(trig_i),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .pulse_o(pulse_o), .busy_o(busy_o), .done_o(done_o),
    .underrun_o(underrun_o), .reload_req_o(reload_req_o),
    .reload_sel_o(reload_sel_o)
  );

  always #5 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  // tick every 4 clocks
  int div = 0;
  always @(negedge clk) begin
    tick_i = (div == 3);
    div = (div + 1) % 4;
  end

  typedef struct { int kind; int val; } item_t;  // kind 0 delay, 1 high, 2 low
  item_t exp_q[$];

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      finish_run();
    end
  end

  // monitor
  logic tick_seen = 1'b0, arm_s = 1'b0;
  always @(posedge clk) begin
    tick_seen <= tick_i;
    arm_s     <= trig_i && !busy_o && rst_ni;
  end

  int idx = 0, t0 = 0, rise_idx = 0, fall_idx = 0, done_cnt = 0;
  bit waiting = 0, first = 0;
  logic last_lvl = 1'b0;

  task automatic got(input int kind, input int val);
    item_t e;
    string tag;
    tag = (kind == 0) ? "R2 delay" : "R3 segment";
    if (exp_q.size() == 0) begin
      check(0, "R3 unexpected segment", val, -1);
    end else begin
      e = exp_q.pop_front();
      check(e.kind == kind, "R3 segment kind", kind, e.kind);
      check(e.val == val, tag, val, e.val);
    end
  endtask

  always @(negedge clk) begin
    if (done_o) done_cnt++;
    if (tick_seen) begin
      idx++;
      if (waiting) begin t0 = idx; waiting = 0; end
      if (pulse_o !== last_lvl) begin
        if (pulse_o) begin
          if (first) begin got(0, idx - t0); first = 0; end
          else got(2, idx - fall_idx);
          rise_idx = idx;
        end else begin
          got(1, idx - rise_idx);
          fall_idx = idx;
        end
        last_lvl = pulse_o;
      end
    end
    if (arm_s) begin waiting = 1; first = 1; end
  end

  task automatic host_wr(input logic [1:0] a, input int v);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = DW'(v);
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic pulse_trig();
    trig_i = 1'b1;
    @(negedge clk);
    trig_i = 1'b0;
  endtask

  task automatic run_seq(input int d, input int durs[8], input int late,
                         input bit poke, input bit retrig, input bit noreload);
    item_t it;
    int cnt;
    @(negedge clk);
    host_wr(2'd0, d);
    host_wr(2'd1, durs[0]);
    host_wr(2'd2, durs[1]);
    done_cnt = 0;
    it.kind = 0; it.val = d;
    if (durs[0] != 0) exp_q.push_back(it);
    for (int i = 0; i < 8; i++) begin
      if (durs[i] == 0) break;
      if (noreload && i >= 2) break;
      if (i % 2 == 0) begin it.kind = 1; it.val = durs[i]; exp_q.push_back(it); end
      else if (i < 7 && durs[i+1] != 0 && !noreload) begin
        it.kind = 2; it.val = durs[i]; exp_q.push_back(it);
      end
    end
    pulse_trig();
    check(busy_o == 1'b1, "R2 busy after trigger", busy_o, 1);
    check(underrun_o == 1'b0, "R6 underrun cleared by trigger", underrun_o, 0);
    if (poke) begin
      while (!pulse_o) @(negedge clk);
      host_wr(2'd1, 1);  // targets running high counter
      check(reload_req_o == 1'b0, "R9 no request from ignored write", reload_req_o, 0);
    end
    if (!noreload) begin
      for (int i = 2; i < 8; i++) begin
        while (!reload_req_o && busy_o) @(negedge clk);
        if (!busy_o) break;
        check(reload_sel_o == i[0], "R4 reload select", reload_sel_o, i % 2);
        if (late == i) begin
          cnt = 0;
          #1;
          if (tick_i) cnt++;
          while (cnt < durs[i-1]) begin
            @(negedge clk); #1;
            if (tick_i) cnt++;
          end
        end
        host_wr(i[1:0] == 2'd0 ? 2'd1 : (i % 2 == 0 ? 2'd1 : 2'd2), durs[i]);
        check(!(reload_req_o && reload_sel_o == i[0]), "R5 request cleared by write",
              reload_req_o, 0);
        if (retrig && i == 2) pulse_trig();
        if (durs[i] == 0) break;
      end
    end
    while (busy_o) @(negedge clk);
    repeat (12) @(negedge clk);
    check(exp_q.size() == 0, "R3 all segments seen", exp_q.size(), 0);
    check(pulse_o == 1'b0, "R7 output low at end", pulse_o, 0);
    check(done_cnt == (noreload ? 0 : 1), "R7 done pulses", done_cnt, noreload ? 0 : 1);
    check(underrun_o == noreload, "R6 underrun flag", underrun_o, noreload);
    exp_q.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(pulse_o == 0, "R1 pulse reset", pulse_o, 0);
    check(busy_o == 0, "R1 busy reset", busy_o, 0);
    check(done_o == 0, "R1 done reset", done_o, 0);
    check(underrun_o == 0, "R1 underrun reset", underrun_o, 0);
    check(reload_req_o == 0, "R1 request reset", reload_req_o, 0);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);

    run_seq(3, '{4, 2, 3, 5, 0, 0, 0, 0}, 0, 0, 0, 0);
    run_seq(0, '{2, 6, 1, 3, 2, 0, 0, 0}, 0, 0, 0, 0);
    // R5: reload lands on expiry tick
    run_seq(2, '{3, 3, 4, 2, 0, 0, 0, 0}, 2, 0, 0, 0);
    run_seq(2, '{2, 5, 3, 4, 0, 0, 0, 0}, 3, 0, 0, 0);
    // R8 and R9
    run_seq(1, '{5, 3, 0, 0, 0, 0, 0, 0}, 0, 1, 1, 0);
    repeat (20) @(negedge clk);
    check(busy_o == 0, "R8 no restart after ignored trigger", busy_o, 0);
    // R6 missed reload
    run_seq(2, '{3, 2, 0, 0, 0, 0, 0, 0}, 0, 0, 0, 1);
    run_seq(1, '{2, 2, 0, 0, 0, 0, 0, 0}, 0, 0, 0, 0);
    // R7 zero first segment
    run_seq(2, '{0, 3, 0, 0, 0, 0, 0, 0}, 0, 0, 0, 0);
    finish_run();
  end
endmodule